// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the transmit line of a UART into the short light pulses used by serial infrared links at standard rates. It runs from a clock at sixteen times the baud rate, so one bit lasts sixteen clock cycles. Each zero bit on the serial line produces one narrow, active-high pulse near the middle of its bit slot. A one bit produces no pulse. An idle line that rests high keeps the emitter dark.

The block has no framing input and works out the bit boundaries on its own. Every falling edge of the serial line restarts a bit-phase counter. The counter keeps running through a long low stretch, so every zero slot in a run gets its own pulse. A configurable synchronizer sits in front of the line for the case where it is not clocked by the sixteen-times clock. Its depth adds a fixed delay that shifts the whole output pattern without changing its shape.

Top module: `irsir_pulse_enc`

## Requirements
- R1: While `rst` is high at a clock edge, `ir_tx_out` is low after that edge, whatever `txd_in` does. The line state after reset is taken as high (idle).
- R2: Each zero bit (`txd_in` = 0 for a 16-cycle slot) produces exactly one pulse on `ir_tx_out` that stays high for exactly 3 consecutive cycles.
- R3: Counting the first clock edge that samples a zero slot as edge 0, the pulse rises at edge SYNC_STAGES+7 (edge 9 with the default of 2 stages) and falls at edge SYNC_STAGES+10.
- R4: A one bit (`txd_in` = 1 for a slot) and an idle high line produce no pulse, and `ir_tx_out` stays low.
- R5: A run of consecutive zero slots gives one pulse per slot, with pulses exactly 16 cycles apart.
- R6: Every high-to-low change of `txd_in` restarts the slot timing, even when it arrives partway through a slot of the free-running counter. The next pulse then follows R3 measured from that change.
- R7: `txd_in` passes through SYNC_STAGES flip-flops (default 2; 0 means no synchronizer). The stage count only delays the output pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at sixteen times the baud rate |
| rst | input | 1 | Synchronous reset, active high |
| txd_in | input | 1 | UART transmit line; 1 = mark/idle, 0 = space |
| ir_tx_out | output | 1 | Infrared emitter drive, active high |

## Verification
The bench targets frames whose next start bit lands at an offset that is not a multiple of sixteen from the previous frame. A design that does not restart its phase on each falling edge would place those pulses at the wrong cycle. A run of zero bytes and a long break check that pulses repeat in every slot and do not fire only once per falling edge. Single isolated zero bits check the exact rise cycle, which an error of one cycle in the delay or synchronizer count would shift. A reset that arrives in the middle of a pulse checks that the emitter goes dark at once and does not finish the pulse.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

  // Advance a bit-phase value by one within a slot of slot_len cycles.
  function automatic int unsigned slot_next(int unsigned phase, int unsigned slot_len);
    return (phase + 1) % slot_len;
  endfunction

  // True when phase is the sampling point that may launch a pulse.
  function automatic bit is_launch(int unsigned phase, int unsigned delay, bit line);
    return (phase == delay) && !line;
  endfunction

  typedef enum logic [0:0] {PG_DARK = 1'b0, PG_LIT = 1'b1} pg_state_e;

endpackage

// File: rtl/irsir_in_sync.sv
module irsir_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign line_out = line_in;
    end else begin : g_chain
      logic [STAGES-1:0] stage_q;
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            stage_q[g] <= 1'b1;
          end else begin
            if (g == 0) begin
              stage_q[g] <= line_in;
            end else begin
              stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
          end
        end
      end
      assign line_out = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/irsir_slot_timer.sv
module irsir_slot_timer #(
  parameter int unsigned SLOT_CYCLES = 16,
  parameter int unsigned PH_W        = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line,
  output logic            fall_evt,
  output logic [PH_W-1:0] phase_cur
);

  logic            line_d;
  logic [PH_W-1:0] phase_q;

  assign fall_evt  = line_d && !line;
  assign phase_cur = fall_evt ? '0 : phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_d  <= 1'b1;
      phase_q <= '0;
    end else begin
      line_d  <= line;
      phase_q <= PH_W'(irsir_pkg::slot_next(int'(phase_cur), SLOT_CYCLES));
    end
  end

endmodule

// File: rtl/irsir_pulse_gen.sv
module irsir_pulse_gen #(
  parameter int unsigned PULSE_DELAY  = 7,
  parameter int unsigned PULSE_CYCLES = 3,
  parameter int unsigned PH_W         = 4,
  parameter int unsigned LEN_W        = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line,
  input  logic [PH_W-1:0] phase_cur,
  output logic            start_evt,
  output logic            ir_out
);
  import irsir_pkg::*;

  pg_state_e        state_q;
  logic [LEN_W-1:0] remain_q;

  assign start_evt = is_launch(int'(phase_cur), PULSE_DELAY, line);
  assign ir_out    = (state_q == PG_LIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PG_DARK;
      remain_q <= '0;
    end else if (start_evt) begin
      state_q  <= PG_LIT;
      remain_q <= LEN_W'(PULSE_CYCLES - 1);
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end else begin
      state_q  <= PG_DARK;
    end
  end

endmodule

// File: rtl/irsir_pulse_enc.sv
module irsir_pulse_enc #(
  parameter int unsigned SLOT_CYCLES  = 16,
  parameter int unsigned PULSE_DELAY  = 7,
  parameter int unsigned PULSE_CYCLES = 3,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_in,
  output logic ir_tx_out
);

  localparam int unsigned PH_W  = $clog2(SLOT_CYCLES);
  localparam int unsigned LEN_W = $clog2(PULSE_CYCLES + 1);

  logic            txd_sync;
  logic            fall_evt;
  logic            start_evt;
  logic [PH_W-1:0] phase_cur;

  irsir_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .line_in  (txd_in),
    .line_out (txd_sync)
  );

  irsir_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES), .PH_W(PH_W)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .line      (txd_sync),
    .fall_evt  (fall_evt),
    .phase_cur (phase_cur)
  );

  irsir_pulse_gen #(
    .PULSE_DELAY  (PULSE_DELAY),
    .PULSE_CYCLES (PULSE_CYCLES),
    .PH_W         (PH_W),
    .LEN_W        (LEN_W)
  ) pulse_i (
    .clk       (clk),
    .rst       (rst),
    .line      (txd_sync),
    .phase_cur (phase_cur),
    .start_evt (start_evt),
    .ir_out    (ir_tx_out)
  );

endmodule

// File: rtl/irsir_pulse_enc_chk.sv
module irsir_pulse_enc_chk #(
  parameter int unsigned SLOT_CYCLES  = 16,
  parameter int unsigned PULSE_DELAY  = 7,
  parameter int unsigned PULSE_CYCLES = 3,
  parameter int unsigned PH_W         = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            txd_sync,
  input logic            fall_evt,
  input logic            start_evt,
  input logic [PH_W-1:0] phase_cur,
  input logic            ir_out
);

  int unsigned run_len;
  int unsigned since_fall;
  logic        seen_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len    <= 0;
      since_fall <= 0;
      seen_fall  <= 1'b0;
    end else begin
      run_len <= ir_out ? run_len + 1 : 0;
      if (fall_evt) begin
        since_fall <= 1;
        seen_fall  <= 1'b1;
      end else if (since_fall < 32'h7fff_ffff) begin
        since_fall <= since_fall + 1;
      end
    end
  end

  AST_RESET_DARK: assert property (@(posedge clk) rst |=> !ir_out); // R1

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(ir_out) && !$past(rst)) |-> (run_len == PULSE_CYCLES)); // R2

  AST_RISE_AT_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_out) |-> ($past(phase_cur) == PH_W'(PULSE_DELAY))); // R3

  AST_RISE_NEEDS_SPACE: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_out) |-> !$past(txd_sync)); // R4

  AST_START_ONLY_DARK: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> !txd_sync); // R4

  AST_SLOT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_out) |-> (seen_fall && since_fall >= PULSE_DELAY + 1 &&
                       ((since_fall - PULSE_DELAY - 1) % SLOT_CYCLES) == 0)); // R6

endmodule

bind irsir_pulse_enc irsir_pulse_enc_chk #(
  .SLOT_CYCLES  (SLOT_CYCLES),
  .PULSE_DELAY  (PULSE_DELAY),
  .PULSE_CYCLES (PULSE_CYCLES),
  .PH_W         (PH_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .txd_sync  (txd_sync),
  .fall_evt  (fall_evt),
  .start_evt (start_evt),
  .phase_cur (phase_cur),
  .ir_out    (ir_tx_out)
);

// File: tb/irsir_pulse_enc_tb_top.sv
`timescale 1ns/1ps
module irsir_pulse_enc_tb_top;

  localparam int SLOT = 16;
  localparam int PW   = 3;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txd = 1'b1;
  logic ir;
  int   edge_cnt = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  irsir_pulse_enc dut_i (.clk(clk), .rst(rst), .txd_in(txd), .ir_tx_out(ir));

  // Output expected off edges past the first sampling edge of a slot stream.
  function automatic bit exp_ir(int off, logic [63:0] bits, int n);
    if (off < 0) return 1'b0;
    if (off / SLOT >= n) return 1'b0;
    return ((off % SLOT) < PW) && !bits[off / SLOT];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge=%0d ir_tx_out=%0b expected=%0b", tag, edge_cnt, act, exp);
    end
  endtask

  task automatic run_burst(logic [63:0] bits, int n, int tail, string tag);
    int e0 = 0;
    for (int i = 0; i < n * SLOT + tail; i++) begin
      @(negedge clk);
      if (i == 0) e0 = edge_cnt + 1;
      check(tag, ir, exp_ir(edge_cnt - e0 - LAT, bits, n));
      txd = (i < n * SLOT) ? bits[i / SLOT] : 1'b1;
    end
  endtask

  task automatic idle_check(int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(tag, ir, 1'b0);
      txd = 1'b1;
    end
  endtask

  function automatic logic [63:0] frames(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    logic [63:0] v = '1;
    logic [7:0]  d[3];
    d[0] = b0; d[1] = b1; d[2] = b2;
    for (int f = 0; f < 3; f++) begin
      v[f*10] = 1'b0;
      for (int k = 0; k < 8; k++) v[f*10 + 1 + k] = d[f][k];
      v[f*10 + 9] = 1'b1;
    end
    return v;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    // R1: reset holds the output low even with the line low
    txd = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R1", ir, 1'b0);
    end
    txd = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle_check(40, "R4");

    // R3: isolated zero bit, exact rise and fall cycle
    run_burst(64'b10, 2, 20, "R3");
    // R4: only marks, no pulses
    run_burst(64'hFFFF, 16, 10, "R4");
    // R5: zero byte and a long break
    run_burst(frames(8'h00, 8'h00, 8'h00), 10, 0, "R5");
    run_burst(64'hFFFF_FFFF_FFFF_FF00, 10, 8, "R5");
    // R2: alternating and directed bytes
    run_burst(frames(8'h55, 8'hAA, 8'hFF), 30, 3, "R2");
    // R6: next start lands mid-slot of the running counter
    run_burst(frames(8'h0F, 8'h00, 8'h00), 10, 5, "R6");
    run_burst(frames(8'hF0, 8'h00, 8'h00), 10, 11, "R6");
    run_burst(64'b10, 2, 1, "R6");
    // R7: latency including synchronizer depth
    run_burst(frames(8'h01, 8'h80, 8'h00), 20, 0, "R7");

    // Random frames with random inter-frame gaps
    for (int b = 0; b < 40; b++) begin
      int nf = 1 + int'($urandom_range(2, 0));
      run_burst(frames(8'($urandom), 8'($urandom), 8'($urandom)), nf * 10,
                int'($urandom_range(37, 0)), (b % 2 == 0) ? "R2" : "R6");
    end
    idle_check(40, "R4");

    // R1: reset during a pulse darkens the emitter at once
    @(negedge clk);
    txd = 1'b0;
    for (int i = 0; i < 30 && ir !== 1'b1; i++) @(negedge clk);
    check("R1", ir, 1'b1);
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", ir, 1'b0);
      txd = 1'b1;
    end
    rst = 1'b0;
    idle_check(40, "R4");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired ir_tx_out=%0b expected=done", ir);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule